// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block turns a free-running 256 Hz prescaler tick into a periodic interrupt. A 3-bit rate code picks how many ticks make up one period. The available rates are 256, 64, 16, 4, 2 and 1 Hz. A code of zero, or the reserved code 7, turns the interrupt off. Each completed period sets a sticky event flag. The interrupt line is a level that follows the flag while a valid rate is selected.

Software drives the block through one 8-bit control byte. A write loads the rate code from bits 6:4. Writing 0 to bit 7 clears the flag, and writing 1 to bit 7 leaves the flag as it is. The same byte reads back on `ctrl_o`. When a write changes the rate code, the tick divider restarts, so the first period after the change is always a full one.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset, `ctrl_o` is 0x00, and `flag_o` and `irq_o` are both low.
- R2: `ctrl_o` holds the flag in bit 7 and the rate code in bits 6:4, and bits 3:0 always read 0. A write loads bits 6:4 of `wr_data_i` into the rate code on the next clock.
- R3: The rate code sets the period length in ticks: code 1 = 1 tick (256 Hz), code 2 = 4 ticks, code 3 = 16, code 4 = 64, code 5 = 128 and code 6 = 256. The flag rises on the clock edge that samples the last tick of a period, and never without a tick.
- R4: Codes 0 and 7 disable the generator. While either is selected, no tick sets the flag and the divider stays cleared.
- R5: The flag is sticky. A write with bit 7 = 0 clears it. A write with bit 7 = 1 leaves it unchanged.
- R6: `irq_o` equals the flag while the rate code is 1 to 6, and is 0 otherwise. A flag set under a valid code stays visible in `ctrl_o` after the code is changed to 0 or 7.
- R7: A write that changes the rate code restarts the divider. A tick sampled in the same cycle as that write is not counted, so the next flag needs a full period of the new code. A write that keeps the same code does not restart the divider.
- R8: If a period ends in the same cycle as a write that clears the flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse at 256 Hz from the prescaler |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write data (bit 7 flag, bits 6:4 rate code) |
| ctrl_o | output | 8 | Control byte readback |
| flag_o | output | 1 | Sticky period flag |
| irq_o | output | 1 | Periodic interrupt level |

## Verification
Two things can happen in the same cycle: a period can end while software writes the control byte. The bench provokes this by raising `tick_i` on the cycle of a write, at rate code 1, where every tick ends a period. It does this once with a write that clears the flag and keeps the code, where the flag must survive. It does it again with a write that changes the code, where the tick must be dropped and the flag must stay clear until a full new period has passed. A behavioural model built from the requirements predicts the flag, interrupt and readback on every cycle, and directed checks pin each period length by counting ticks.

// File: rtl/pig_pkg.sv
package pig_pkg;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = 3;
  localparam int SEL_LSB  = 4;
  localparam int FLAG_BIT = 7;
  localparam int CNT_W    = 8;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // codes 1..6 are live rates; 0 and 7 are off
  function automatic logic sel_active(sel_t s);
    return (s != '0) && (s != '1);
  endfunction

  // last count value of a period: ticks per period minus one
  function automatic cnt_t period_last(sel_t s);
    cnt_t n;
    case (s)
      3'd1, 3'd2, 3'd3, 3'd4: n = cnt_t'((1 << (2 * (int'(s) - 1))) - 1);
      3'd5:                   n = cnt_t'(127);
      3'd6:                   n = cnt_t'(255);
      default:                n = '0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/pig_divider.sv
module pig_divider
  import pig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  input  logic tick_i,
  input  cnt_t last_i,
  output logic wrap_o
);
  cnt_t cnt_q;

  assign wrap_o = en_i && !restart_i && tick_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || !en_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pig_ctrl.sv
module pig_ctrl
  import pig_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  sel_t wr_sel_i,
  input  logic wr_flag_i,
  input  logic wrap_i,
  output sel_t sel_o,
  output logic flag_o,
  output logic restart_o
);
  sel_t sel_q;
  logic flag_q;

  assign restart_o = wr_en_i && (wr_sel_i != sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en_i) sel_q <= wr_sel_i;
      // a period end beats a software clear
      if (wrap_i)                      flag_q <= 1'b1;
      else if (wr_en_i && !wr_flag_i)  flag_q <= 1'b0;
    end
  end

  assign sel_o  = sel_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              flag_o,
  output logic              irq_o
);
  sel_t sel;
  logic restart, wrap, active;

  assign active = sel_active(sel);

  pig_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_data_i[SEL_LSB +: SEL_W]),
    .wr_flag_i (wr_data_i[FLAG_BIT]),
    .wrap_i    (wrap),
    .sel_o     (sel),
    .flag_o    (flag_o),
    .restart_o (restart)
  );

  pig_divider u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (active),
    .restart_i (restart),
    .tick_i    (tick_i),
    .last_i    (period_last(sel)),
    .wrap_o    (wrap)
  );

  assign irq_o = flag_o && active;

  always_comb begin
    ctrl_o = '0;
    ctrl_o[FLAG_BIT] = flag_o;
    ctrl_o[SEL_LSB +: SEL_W] = sel;
  end
endmodule

// File: rtl/periodic_irq_gen_chk.sv
module periodic_irq_gen_chk
  import pig_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] ctrl_o,
  input logic              flag_o,
  input logic              irq_o
);
  sel_t sel_rd;
  assign sel_rd = ctrl_o[SEL_LSB +: SEL_W];

  AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[SEL_LSB-1:0] == '0);  // R2
  AST_SEL_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> sel_rd == $past(wr_data_i[SEL_LSB +: SEL_W]));  // R2
  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !tick_i) |=> !flag_o);  // R3
  AST_OFF_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && (sel_rd == 3'd0 || sel_rd == 3'd7)) |=> !flag_o);  // R4
  AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !(wr_en_i && !wr_data_i[FLAG_BIT])) |=> flag_o);  // R5
  AST_CLEAR_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[FLAG_BIT] && !tick_i) |=> !flag_o);  // R5
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (flag_o && sel_rd != 3'd0 && sel_rd != 3'd7));  // R6
endmodule

bind periodic_irq_gen periodic_irq_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .ctrl_o    (ctrl_o),
  .flag_o    (flag_o),
  .irq_o     (irq_o)
);

// File: tb/periodic_irq_gen_bench.sv
`timescale 1ns/1ps
module periodic_irq_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] ctrl;
  logic flag, irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0;
  int m_sel = 0;
  bit m_flag = 0;

  always #2 clk = ~clk;

  periodic_irq_gen u_periodic_irq_gen (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr),
    .wr_data_i(wd), .ctrl_o(ctrl), .flag_o(flag), .irq_o(irq)
  );

  function automatic int ticks_for(int code);
    case (code)
      1: return 1;
      2: return 4;
      3: return 16;
      4: return 64;
      5: return 128;
      6: return 256;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; m_flag = 0;
    end else begin
      int len;
      bit set_now;
      bit chg;
      len = ticks_for(m_sel);
      chg = wr && (int'(wd[6:4]) != m_sel);
      set_now = 0;
      if (chg || len == 0) m_cnt = 0;
      else if (tick) begin
        if (m_cnt == len - 1) begin set_now = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (set_now) m_flag = 1;
      else if (wr && !wd[7]) m_flag = 0;
      if (wr) m_sel = int'(wd[6:4]);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      logic [7:0] exp_ctrl;
      exp_ctrl = {m_flag, 3'(m_sel), 4'h0};
      chk("R2 model ctrl", ctrl, exp_ctrl);
      chk("R3 model flag", {7'd0, flag}, {7'd0, m_flag});
      chk("R6 model irq", {7'd0, irq}, {7'd0, m_flag && m_sel >= 1 && m_sel <= 6});
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic do_tick(int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic do_wr(logic [7:0] d, bit with_tick);
    @(negedge clk) begin wr = 1'b1; wd = d; tick = with_tick; end
    @(negedge clk) begin wr = 1'b0; tick = 1'b0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ctrl", ctrl, 8'h00);
    chk("R1 reset flag", {7'd0, flag}, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;

    do_tick(300);
    chk("R4 code0 no flag", {7'd0, flag}, 8'h00);
    do_wr(8'h7F, 0);
    chk("R2 low bits read zero", ctrl, 8'h70);
    do_tick(300);
    chk("R4 code7 no flag", {7'd0, flag}, 8'h00);
    chk("R4 code7 no irq", {7'd0, irq}, 8'h00);

    for (int c = 1; c <= 6; c++) begin
      do_wr({1'b0, 3'(c), 4'h0}, 0);
      if (ticks_for(c) > 1) begin
        do_tick(ticks_for(c) - 1);
        chk($sformatf("R3 code%0d early", c), {7'd0, flag}, 8'h00);
      end
      do_tick(1);
      chk($sformatf("R3 code%0d period end", c), {7'd0, flag}, 8'h01);
      chk($sformatf("R6 code%0d irq", c), {7'd0, irq}, 8'h01);
      chk($sformatf("R2 code%0d readback", c), ctrl, {1'b1, 3'(c), 4'h0});
    end

    do_wr(8'hE0, 0);
    chk("R5 write one keeps flag", {7'd0, flag}, 8'h01);
    do_tick(5);
    chk("R5 flag sticky", {7'd0, flag}, 8'h01);
    do_wr(8'h60, 0);
    chk("R5 write zero clears", {7'd0, flag}, 8'h00);
    do_tick(256);
    chk("R5 set again", {7'd0, flag}, 8'h01);
    do_wr(8'hF0, 0);
    chk("R6 code7 masks irq", {7'd0, irq}, 8'h00);
    chk("R6 flag kept under code7", ctrl, 8'hF0);
    do_wr(8'h80, 0);
    chk("R6 code0 masks irq", {7'd0, irq}, 8'h00);
    do_wr(8'h00, 0);

    do_wr(8'h30, 0);
    do_tick(10);
    do_wr(8'h40, 0);
    do_tick(63);
    chk("R7 restart full period", {7'd0, flag}, 8'h00);
    do_tick(1);
    chk("R7 restart period end", {7'd0, flag}, 8'h01);

    do_wr(8'h20, 0);
    do_tick(2);
    do_wr(8'h20, 0);
    do_tick(2);
    chk("R7 same code no restart", {7'd0, flag}, 8'h01);

    do_wr(8'h20, 0);
    do_wr(8'h10, 1);
    chk("R7 tick on changing write dropped", {7'd0, flag}, 8'h00);
    do_tick(1);
    chk("R7 next tick sets", {7'd0, flag}, 8'h01);

    do_wr(8'h10, 1);
    chk("R8 set beats clear", {7'd0, flag}, 8'h01);
    do_wr(8'h10, 0);
    chk("R8 clear alone", {7'd0, flag}, 8'h00);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule